// File: doc/BRIEF.md
# Dual-Clock FIFO Flag Generator

This block is the control half of a FIFO whose writer and reader run on unrelated clocks. It keeps a write pointer and a read pointer, passes each one to the opposite clock domain as Gray code through a multi-stage synchronizer, and works out the number of unread words separately in each domain. From those counts it drives four active-low flags. Full and almost-full are registered on the write clock. Empty and almost-empty are registered on the read clock. It also gates the caller's write and read enables, so that a full FIFO refuses writes and an empty FIFO refuses reads. The storage array sits outside the block and is addressed through the two address outputs.

The two threshold flags use user-supplied levels, and their boundaries are deliberately not symmetric. Almost-empty is asserted while the read side sees at most `aempty_lvl` words. Almost-full is asserted while the write side sees at least `2**AW - afull_lvl` words. Each domain sees the far pointer only after synchronizer delay. Because of that, a flag may be released late but is never released early, so the FIFO can neither overflow nor underflow.

Top module: `dcfifo_flags`

## Requirements
- R1: While its reset is held low, each domain puts its flags in the idle state: `rd_empty_n` = 0 and `rd_aempty_n` = 0 on the read side, and `wr_full_n` = 1 and `wr_afull_n` = 1 on the write side. Both pointers restart at address 0.
- R2: Once the pointers have settled, `rd_empty_n` is 0 when no word is unread and 1 when at least one word is unread.
- R3: While `rd_empty_n` is 0, `rd_accept` stays 0 whatever the value of `rd_en`, and `rd_addr` does not move.
- R4: Once the pointers have settled, `wr_full_n` is 0 when `2**AW` words are unread and 1 otherwise. While it is 0, `wr_accept` stays 0 whatever the value of `wr_en`, and `wr_addr` does not move.
- R5: Once the pointers have settled, `rd_aempty_n` is 0 when the unread count is at most `aempty_lvl` and 1 when it is `aempty_lvl + 1` or more. Whenever `rd_empty_n` is 0, `rd_aempty_n` is also 0.
- R6: Once the pointers have settled, `wr_afull_n` is 0 when the unread count is at least `2**AW - afull_lvl` and 1 below that. Whenever `wr_full_n` is 0, `wr_afull_n` is also 0.
- R7: Flags are pessimistic. A write is never accepted when `2**AW` words are unread, and a read is never accepted when no word is unread, including under concurrent traffic. After a write, `rd_empty_n` stays 0 for at least the first read-clock edge that follows.
- R8: `wr_accept` = `wr_en & wr_full_n` and `rd_accept` = `rd_en & rd_empty_n`, both combinational. Each accepted operation advances its address by one, modulo `2**AW`, at the next edge of its own clock. Reads visit addresses in the order in which writes filled them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain synchronous reset, active low |
| wr_en | input | 1 | Write request |
| afull_lvl | input | AW | Free-space margin m for almost-full |
| wr_accept | output | 1 | Write taken this cycle (request and not full) |
| wr_addr | output | AW | Storage address for the next write |
| wr_full_n | output | 1 | Full flag, active low |
| wr_afull_n | output | 1 | Almost-full flag, active low |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain synchronous reset, active low |
| rd_en | input | 1 | Read request |
| aempty_lvl | input | AW | Word-count level n for almost-empty |
| rd_accept | output | 1 | Read taken this cycle (request and not empty) |
| rd_addr | output | AW | Storage address for the next read |
| rd_empty_n | output | 1 | Empty flag, active low |
| rd_aempty_n | output | 1 | Almost-empty flag, active low |

## Verification
An accepted write and an accepted read can land in the same stretch of cycles. The dangerous case is when the FIFO sits one word from full or one word from empty: each side then works from a stale copy of the other's pointer. The bench provokes this with two clocks of unrelated period and two concurrent traffic phases, one that drives the FIFO into full and one that drains it to empty, using enable patterns that differ between the two sides. Every accepted operation is judged against an occupancy kept by the bench, which must never exceed the depth or drop below zero. A queue of accepted write addresses is also popped in order and compared with each accepted read address.

// File: rtl/dcfifo_pkg.sv
// Package: shared constants for the dual-clock FIFO flag generator.
// Assumes: nothing; it holds only compile-time values.
package dcfifo_pkg;
    // Smallest synchronizer depth considered safe for metastability settling
    localparam int unsigned SYNC_MIN = 2;
    // Pointer width given an address width (one extra wrap bit)
    function automatic int unsigned ptr_width(input int unsigned aw);
        return aw + 1;
    endfunction
endpackage

// File: rtl/dcfifo_sync.sv
// Module: dcfifo_sync
// Carries a Gray-coded vector into the destination clock domain through a
// chain of STAGES flip-flops.
// Assumes: the source changes at most one bit between successive values,
// and the reset is synchronous to the destination clock.
module dcfifo_sync #(
    parameter int unsigned W      = 11,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First capture stage: samples the asynchronous source
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d;
            end
        end else begin : g_next
            // Later stages: give a metastable value time to resolve
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcfifo_gray2bin.sv
// Module: dcfifo_gray2bin
// Converts a Gray-coded value back to plain binary.
// Assumes: purely combinational; the caller registers the result if needed.
module dcfifo_gray2bin #(
    parameter int unsigned W = 11
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    // Prefix XOR from the most significant bit downward
    always_comb begin
        bin[W-1] = gray[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin[i] = bin[i+1] ^ gray[i];
        end
    end
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
// Module: dcfifo_wr_ctrl
// Write-domain controller. Keeps the binary write pointer, publishes it as
// Gray code, and registers the full and almost-full flags from the count the
// pointer will give after this cycle.
// Assumes: rgray_s is the read pointer already synchronized to clk, and
// afull_lvl is quasi-static.
module dcfifo_wr_ctrl #(
    parameter int unsigned AW = 10,
    localparam int unsigned PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] afull_lvl,
    input  logic [PW-1:0] rgray_s,
    output logic          accept,
    output logic [AW-1:0] addr,
    output logic [PW-1:0] wgray,
    output logic          full_n,
    output logic          afull_n
);
    localparam logic [PW-1:0] FULL_CNT = {1'b1, {AW{1'b0}}};

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] cnt_nx;
    logic [PW-1:0] afull_thr;

    dcfifo_gray2bin #(.W(PW)) u_rconv (
        .gray (rgray_s),
        .bin  (rbin_s)
    );

    // Gate the request and form the next pointer and occupancy
    always_comb begin
        accept    = en & full_n;
        wbin_nx   = wbin + PW'(accept);
        cnt_nx    = wbin_nx - rbin_s;
        afull_thr = FULL_CNT - {1'b0, afull_lvl};
    end

    // Pointer and flag registers of the write domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin    <= '0;
            wgray   <= '0;
            full_n  <= 1'b1;
            afull_n <= 1'b1;
        end else begin
            wbin    <= wbin_nx;
            wgray   <= wbin_nx ^ (wbin_nx >> 1);
            full_n  <= (cnt_nx != FULL_CNT);
            afull_n <= (cnt_nx < afull_thr);
        end
    end

    assign addr = wbin[AW-1:0];
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
// Module: dcfifo_rd_ctrl
// Read-domain controller. Keeps the binary read pointer, publishes it as
// Gray code, and registers the empty and almost-empty flags from the count
// the pointer will give after this cycle.
// Assumes: wgray_s is the write pointer already synchronized to clk, and
// aempty_lvl is quasi-static.
module dcfifo_rd_ctrl #(
    parameter int unsigned AW = 10,
    localparam int unsigned PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] aempty_lvl,
    input  logic [PW-1:0] wgray_s,
    output logic          accept,
    output logic [AW-1:0] addr,
    output logic [PW-1:0] rgray,
    output logic          empty_n,
    output logic          aempty_n
);
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] cnt_nx;

    dcfifo_gray2bin #(.W(PW)) u_wconv (
        .gray (wgray_s),
        .bin  (wbin_s)
    );

    // Gate the request and form the next pointer and occupancy
    always_comb begin
        accept  = en & empty_n;
        rbin_nx = rbin + PW'(accept);
        cnt_nx  = wbin_s - rbin_nx;
    end

    // Pointer and flag registers of the read domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            empty_n  <= 1'b0;
            aempty_n <= 1'b0;
        end else begin
            rbin     <= rbin_nx;
            rgray    <= rbin_nx ^ (rbin_nx >> 1);
            empty_n  <= (cnt_nx != '0);
            aempty_n <= (cnt_nx > {1'b0, aempty_lvl});
        end
    end

    assign addr = rbin[AW-1:0];
endmodule

// File: rtl/dcfifo_flags.sv
// Module: dcfifo_flags (top)
// Flag and pointer control for a dual-clock FIFO of 2**AW words. Ties the
// write controller, the read controller and the two pointer synchronizers
// together.
// Assumes: the storage array is external, is written at wr_addr when
// wr_accept is high and is read at rd_addr when rd_accept is high. Each
// reset is synchronous to its own clock, and both resets are applied
// together.
module dcfifo_flags #(
    parameter int unsigned AW          = 10,
    parameter int unsigned SYNC_STAGES = dcfifo_pkg::SYNC_MIN
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] afull_lvl,
    output logic          wr_accept,
    output logic [AW-1:0] wr_addr,
    output logic          wr_full_n,
    output logic          wr_afull_n,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] aempty_lvl,
    output logic          rd_accept,
    output logic [AW-1:0] rd_addr,
    output logic          rd_empty_n,
    output logic          rd_aempty_n
);
    localparam int unsigned PW = dcfifo_pkg::ptr_width(AW);

    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wgray_s;
    logic [PW-1:0] rgray_s;

    dcfifo_wr_ctrl #(.AW(AW)) u_wr (
        .clk       (wr_clk),
        .rst_n     (wr_rst_n),
        .en        (wr_en),
        .afull_lvl (afull_lvl),
        .rgray_s   (rgray_s),
        .accept    (wr_accept),
        .addr      (wr_addr),
        .wgray     (wgray),
        .full_n    (wr_full_n),
        .afull_n   (wr_afull_n)
    );

    dcfifo_rd_ctrl #(.AW(AW)) u_rd (
        .clk        (rd_clk),
        .rst_n      (rd_rst_n),
        .en         (rd_en),
        .aempty_lvl (aempty_lvl),
        .wgray_s    (wgray_s),
        .accept     (rd_accept),
        .addr       (rd_addr),
        .rgray      (rgray),
        .empty_n    (rd_empty_n),
        .aempty_n   (rd_aempty_n)
    );

    dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rgray),
        .q     (rgray_s)
    );
endmodule

// File: rtl/dcfifo_flags_chk.sv
// Module: dcfifo_flags_chk
// Property checker attached to dcfifo_flags by bind. It observes ports only.
module dcfifo_flags_chk #(
    parameter int unsigned AW = 10
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          wr_accept,
    input logic [AW-1:0] wr_addr,
    input logic          wr_full_n,
    input logic          wr_afull_n,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          rd_accept,
    input logic [AW-1:0] rd_addr,
    input logic          rd_empty_n,
    input logic          rd_aempty_n
);
    // R1: write-side flags idle right after a reset cycle
    assert_wr_reset_flags_R1: assert property (@(posedge wr_clk)
        !wr_rst_n |=> (wr_full_n && wr_afull_n && wr_addr == '0));

    // R1: read-side flags idle right after a reset cycle
    assert_rd_reset_flags_R1: assert property (@(posedge rd_clk)
        !rd_rst_n |=> (!rd_empty_n && !rd_aempty_n && rd_addr == '0));

    // R3: no read is taken while empty
    assert_no_read_when_empty_R3: assert property (@(posedge rd_clk)
        disable iff (!rd_rst_n) !rd_empty_n |-> !rd_accept);

    // R4: no write is taken while full
    assert_no_write_when_full_R4: assert property (@(posedge wr_clk)
        disable iff (!wr_rst_n) !wr_full_n |-> !wr_accept);

    // R4: write address holds when no write is taken
    assert_wr_addr_hold_R4: assert property (@(posedge wr_clk)
        disable iff (!wr_rst_n) !wr_accept |=> $stable(wr_addr));

    // R8: read address steps by one after each taken read
    assert_rd_addr_step_R8: assert property (@(posedge rd_clk)
        disable iff (!rd_rst_n) rd_accept |=> (rd_addr == AW'($past(rd_addr) + 1'b1)));

    // R5: empty implies almost-empty
    assert_aempty_covers_empty_R5: assert property (@(posedge rd_clk)
        disable iff (!rd_rst_n) !rd_empty_n |-> !rd_aempty_n);

    // R6: full implies almost-full
    assert_afull_covers_full_R6: assert property (@(posedge wr_clk)
        disable iff (!wr_rst_n) !wr_full_n |-> !wr_afull_n);
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.AW(AW)) u_chk (
    .wr_clk      (wr_clk),
    .wr_rst_n    (wr_rst_n),
    .wr_accept   (wr_accept),
    .wr_addr     (wr_addr),
    .wr_full_n   (wr_full_n),
    .wr_afull_n  (wr_afull_n),
    .rd_clk      (rd_clk),
    .rd_rst_n    (rd_rst_n),
    .rd_accept   (rd_accept),
    .rd_addr     (rd_addr),
    .rd_empty_n  (rd_empty_n),
    .rd_aempty_n (rd_aempty_n)
);

// File: tb/dcfifo_flags_tb.sv
// Scoreboard bench: the write driver queues each accepted write address, and
// the read monitor pops and compares on each accepted read.
module dcfifo_flags_tb;
    localparam int AW        = 4;
    localparam int DEPTH     = 1 << AW;
    localparam int WR_PERIOD = 10;
    localparam int RD_PERIOD = 14;
    localparam int WD_LIMIT  = WR_PERIOD * 150000;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0;
    logic          rd_rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] afull_lvl = AW'(2);
    logic [AW-1:0] aempty_lvl = AW'(3);
    logic          wr_accept, wr_full_n, wr_afull_n;
    logic          rd_accept, rd_empty_n, rd_aempty_n;
    logic [AW-1:0] wr_addr, rd_addr;

    int n_checks = 0;
    int n_errors = 0;
    int wr_total = 0;
    int rd_total = 0;
    int exp_q[$];
    bit timed_out = 1'b0;

    always #(WR_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2) rd_clk = ~rd_clk;

    dcfifo_flags #(.AW(AW)) u_dut (
        .wr_clk      (wr_clk),
        .wr_rst_n    (wr_rst_n),
        .wr_en       (wr_en),
        .afull_lvl   (afull_lvl),
        .wr_accept   (wr_accept),
        .wr_addr     (wr_addr),
        .wr_full_n   (wr_full_n),
        .wr_afull_n  (wr_afull_n),
        .rd_clk      (rd_clk),
        .rd_rst_n    (rd_rst_n),
        .rd_en       (rd_en),
        .aempty_lvl  (aempty_lvl),
        .rd_accept   (rd_accept),
        .rd_addr     (rd_addr),
        .rd_empty_n  (rd_empty_n),
        .rd_aempty_n (rd_aempty_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: one write-clock cycle of request; queue the address if taken
    task automatic wr_push(input bit en);
        @(negedge wr_clk);
        wr_en = en;
        #1;
        if (wr_accept) begin
            check((wr_total - rd_total) < DEPTH, "R7 write while full", wr_total - rd_total, DEPTH - 1);
            exp_q.push_back(int'(wr_addr));
            wr_total++;
        end
    endtask

    // Monitor: one read-clock cycle of request; pop and compare if taken
    task automatic rd_pop(input bit en);
        int exp;
        @(negedge rd_clk);
        rd_en = en;
        #1;
        if (rd_accept) begin
            check((wr_total - rd_total) > 0, "R7 read while empty", wr_total - rd_total, 1);
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 queue empty", int'(rd_addr), -1);
            end else begin
                exp = exp_q.pop_front();
                check(int'(rd_addr) == exp, "R8 read order", int'(rd_addr), exp);
            end
            rd_total++;
        end
    endtask

    task automatic write_n(input int k);
        for (int i = 0; i < k; i++) wr_push(1'b1);
        wr_push(1'b0);
    endtask

    task automatic read_n(input int k);
        for (int i = 0; i < k; i++) rd_pop(1'b1);
        rd_pop(1'b0);
    endtask

    task automatic settle;
        repeat (8) @(negedge rd_clk);
        repeat (8) @(negedge wr_clk);
        #1;
    endtask

    task automatic run_all;
        logic [AW-1:0] held;
        // Reset both domains
        repeat (3) @(negedge rd_clk);
        repeat (3) @(negedge wr_clk);
        #1;
        check(rd_empty_n == 1'b0, "R1 empty_n", rd_empty_n, 0);
        check(rd_aempty_n == 1'b0, "R1 aempty_n", rd_aempty_n, 0);
        check(wr_full_n == 1'b1, "R1 full_n", wr_full_n, 1);
        check(wr_afull_n == 1'b1, "R1 afull_n", wr_afull_n, 1);
        check(wr_addr == '0 && rd_addr == '0, "R1 addr", int'(wr_addr), 0);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        settle();

        // R3: reads while empty are refused
        for (int i = 0; i < 3; i++) begin
            rd_pop(1'b1);
            check(rd_accept == 1'b0, "R3 accept", rd_accept, 0);
        end
        rd_pop(1'b0);
        check(rd_addr == '0, "R3 addr hold", int'(rd_addr), 0);

        // R7: one write does not release empty by the first read edge
        write_n(1);
        @(posedge rd_clk);
        #1;
        check(rd_empty_n == 1'b0, "R7 early release", rd_empty_n, 0);
        settle();
        check(rd_empty_n == 1'b1, "R2 one word", rd_empty_n, 1);
        check(rd_aempty_n == 1'b0, "R5 count 1", rd_aempty_n, 0);

        // R5 boundary at n=3 and n+1
        write_n(2);
        settle();
        check(rd_aempty_n == 1'b0, "R5 count n", rd_aempty_n, 0);
        write_n(1);
        settle();
        check(rd_aempty_n == 1'b1, "R5 count n+1", rd_aempty_n, 1);

        // R6 boundary: DEPTH-m = 14
        write_n(9);
        settle();
        check(wr_afull_n == 1'b1, "R6 count 13", wr_afull_n, 1);
        write_n(1);
        settle();
        check(wr_afull_n == 1'b0, "R6 count 14", wr_afull_n, 0);
        check(wr_full_n == 1'b1, "R4 count 14", wr_full_n, 1);

        // R4: fill, then writes are refused
        write_n(2);
        settle();
        check(wr_full_n == 1'b0, "R4 full", wr_full_n, 0);
        held = wr_addr;
        wr_push(1'b1);
        check(wr_accept == 1'b0, "R4 accept", wr_accept, 0);
        wr_push(1'b1);
        wr_push(1'b0);
        check(wr_addr == held, "R4 addr hold", int'(wr_addr), int'(held));

        // One read frees a slot
        read_n(1);
        settle();
        check(wr_full_n == 1'b1, "R4 count 15", wr_full_n, 1);
        check(wr_afull_n == 1'b0, "R6 count 15", wr_afull_n, 0);

        // Drain and compare order
        read_n(15);
        settle();
        check(rd_empty_n == 1'b0, "R2 drained", rd_empty_n, 0);
        check(rd_aempty_n == 1'b0, "R5 drained", rd_aempty_n, 0);

        // R5 with n = 0
        aempty_lvl = '0;
        write_n(1);
        settle();
        check(rd_aempty_n == 1'b1, "R5 n=0 count 1", rd_aempty_n, 1);
        read_n(1);
        aempty_lvl = AW'(3);

        // Concurrent traffic: fill-heavy, then drain-heavy
        fork
            begin
                for (int i = 0; i < 300; i++) wr_push((i % 7) != 3);
                wr_push(1'b0);
            end
            begin
                for (int i = 0; i < 200; i++) rd_pop((i % 3) == 0);
                rd_pop(1'b0);
            end
        join
        fork
            begin
                for (int i = 0; i < 200; i++) wr_push((i % 4) == 1);
                wr_push(1'b0);
            end
            begin
                for (int i = 0; i < 300; i++) rd_pop((i % 5) != 2);
                rd_pop(1'b0);
            end
        join
        settle();
        for (int i = 0; i < 200 && wr_total != rd_total; i++) rd_pop(1'b1);
        rd_pop(1'b0);
        settle();
        check(exp_q.size() == 0, "R8 all reads matched", exp_q.size(), 0);
        check(rd_empty_n == 1'b0, "R2 final empty", rd_empty_n, 0);
        check(wr_addr == rd_addr, "R8 pointers meet", int'(rd_addr), int'(wr_addr));
    endtask

    initial begin
        fork
            run_all();
            begin
                #(WD_LIMIT);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule